// File: doc/BRIEF.md
# I/Q DC Offset Trim Sequencer

This block sits after the decimation filters of a two-channel (in-phase and quadrature) receive path. It removes DC offset from both 15-bit two's-complement sample streams. Each channel has a 10-bit signed trim word. The block scales that word up by four and subtracts it from every filtered sample, then clamps the difference to the 15-bit range.

Each time the receiver leaves sleep, the block follows one of two paths, chosen by a mode input.

- **Automatic path:** the block raises a request that shorts the analog inputs. It averages sixteen measured sample pairs and loads the derived trim words into both channels. It then waits a settling interval before it forwards any corrected pair.
- **Held path:** the trim words are kept as they are, and only a shorter settling interval runs. In this path a control port may also write the trim words.

The analog short switch and the filter are outside this block. They appear only as the request output and the sample-valid input.

Top module: `iq_dc_trim`

## Requirements
- R1: After reset both trim words read zero, and `out_valid` and `short_req` are low.
- R2: In the running state, a pair presented with `smp_valid` high appears one clock later on `out_i`/`out_q`, with `out_valid` high for that one cycle. Each output equals the sample minus four times the sign-extended trim word of its own channel.
- R3: The subtraction result is clamped to the range -16384 to 16383.
- R4: In automatic mode (`cfg_user_mode`=0), the first clock edge that sees `rx_awake` high starts a calibration. `short_req` stays high from then until the sixteenth valid sample pair has been taken, which is sixteen cycles when samples arrive every cycle.
- R5: The trim word loaded by calibration is the sum of the sixteen samples arithmetically shifted right by 4, then shifted right by 2 again (floor), and clamped to -512..511. It is loaded on the edge that takes the sixteenth pair.
- R6: In held mode (`cfg_user_mode`=1), wake-up leaves both trim words unchanged and `short_req` stays low.
- R7: When `ofs_wr_en` is high with `cfg_user_mode`=1, the next edge loads `ofs_wr_data` into the I trim word if `ofs_wr_sel`=0, or into the Q trim word if `ofs_wr_sel`=1. With `cfg_user_mode`=0 the write is ignored.
- R8: With samples valid every cycle, counting the first edge that sees `rx_awake` high as edge 1:
  - In held mode, the first `out_valid` follows edge SETTLE_USER+3.
  - In automatic mode, the first `out_valid` follows edge SETTLE_AUTO+19.
  - `out_valid` is low on every edge before that.
- R9: An edge that sees `rx_awake` low returns the block to sleep, takes priority over any sample on that edge, and leaves `out_valid` and `short_req` low after it. A calibration aborted this way leaves both trim words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_user_mode | input | 1 | 0 = calibrate on every wake, 1 = hold trim words |
| rx_awake | input | 1 | 1 = receiver active, 0 = sleep |
| ofs_wr_en | input | 1 | Trim word write strobe (held mode only) |
| ofs_wr_sel | input | 1 | Write target: 0 = I, 1 = Q |
| ofs_wr_data | input | OFS_W | Two's-complement trim value to write |
| smp_valid | input | 1 | Filtered sample pair valid |
| smp_i | input | SAMP_W | Filtered I sample |
| smp_q | input | SAMP_W | Filtered Q sample |
| short_req | output | 1 | Request to short the analog inputs during calibration |
| out_valid | output | 1 | Corrected pair valid |
| out_i | output | SAMP_W | Corrected I sample |
| out_q | output | SAMP_W | Corrected Q sample |
| ofs_i | output | OFS_W | Current I trim word |
| ofs_q | output | OFS_W | Current Q trim word |

## Verification
A corrupted accumulator or a stuck sample counter is visible on the `ofs_i`/`ofs_q` ports on the cycle calibration ends. A miscounted counter also moves the moment `short_req` falls by at least one cycle. A wrong settle count or a wrong state step shifts the first `out_valid` pulse away from its exact predicted edge. The bench measures that edge to the cycle in both wake paths. Faults in scaling or clamping show up on the very next corrected pair, which the bench compares against hand-computed values that include both range limits.

// File: rtl/iq_trim_pkg.sv
package iq_trim_pkg;

    // Wake-up sequencing states
    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_CAL    = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    localparam int NUM_CH = 2;  // in-phase and quadrature

endpackage

// File: rtl/iq_ofs_avg.sv
// Per-channel accumulator producing a clamped trim estimate.
module iq_ofs_avg #(
    parameter int SAMP_W    = 15,
    parameter int OFS_W     = 10,
    parameter int AVG_LOG2  = 4,
    parameter int OFS_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [SAMP_W-1:0] sample,
    output logic [OFS_W-1:0]  est
);
    localparam int ACC_W = SAMP_W + AVG_LOG2;
    localparam int EMAX  = (1 << (OFS_W - 1)) - 1;
    localparam int EMIN  = -(1 << (OFS_W - 1));
    localparam logic signed [ACC_W-1:0] LIM_HI = ACC_W'(EMAX);
    localparam logic signed [ACC_W-1:0] LIM_LO = ACC_W'(EMIN);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } avg_s;

    avg_s d, q;
    logic signed [ACC_W-1:0] sum_w, mean_w, fld_w;

    always_comb begin
        d      = q;
        sum_w  = $signed(q.acc) + $signed({{AVG_LOG2{sample[SAMP_W-1]}}, sample});
        mean_w = sum_w >>> AVG_LOG2;
        fld_w  = mean_w >>> OFS_SHIFT;
        if (clear) begin
            d.acc = '0;
        end else if (take) begin
            d.acc = sum_w;
        end
        // estimate includes the sample present this cycle
        if (fld_w > LIM_HI) begin
            est = LIM_HI[OFS_W-1:0];
        end else if (fld_w < LIM_LO) begin
            est = LIM_LO[OFS_W-1:0];
        end else begin
            est = fld_w[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/iq_ofs_apply.sv
// Scales a trim word into sample units, subtracts it and clamps.
module iq_ofs_apply #(
    parameter int SAMP_W    = 15,
    parameter int OFS_W     = 10,
    parameter int OFS_SHIFT = 2
) (
    input  logic [SAMP_W-1:0] sample,
    input  logic [OFS_W-1:0]  ofs,
    output logic [SAMP_W-1:0] corr
);
    localparam int DW = SAMP_W + 1;
    localparam logic signed [DW-1:0] OUT_HI = DW'((1 << (SAMP_W - 1)) - 1);
    localparam logic signed [DW-1:0] OUT_LO = DW'(-(1 << (SAMP_W - 1)));

    logic signed [DW-1:0] s_ext, o_ext, diff;

    always_comb begin
        s_ext = {sample[SAMP_W-1], sample};
        o_ext = {{(DW - OFS_W){ofs[OFS_W-1]}}, ofs};
        o_ext = o_ext <<< OFS_SHIFT;
        diff  = s_ext - o_ext;
        if (diff > OUT_HI) begin
            corr = OUT_HI[SAMP_W-1:0];
        end else if (diff < OUT_LO) begin
            corr = OUT_LO[SAMP_W-1:0];
        end else begin
            corr = diff[SAMP_W-1:0];
        end
    end

endmodule

// File: rtl/iq_cal_seq.sv
// Wake-up sequencer: sleep, optional calibration, settle, run.
module iq_cal_seq
    import iq_trim_pkg::*;
#(
    parameter int AVG_LOG2    = 4,
    parameter int SETTLE_AUTO = 10221,
    parameter int SETTLE_USER = 6141
) (
    input  logic clk,
    input  logic rst_n,
    input  logic user_mode,
    input  logic awake,
    input  logic smp_valid,
    output logic cal_active,
    output logic acc_clear,
    output logic cal_take,
    output logic cal_done,
    output logic run_take
);
    localparam int CNT_MAX = (SETTLE_AUTO > SETTLE_USER) ? SETTLE_AUTO : SETTLE_USER;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [AVG_LOG2-1:0] LAST_SMP = '1;

    typedef struct packed {
        seq_state_e          state;
        logic [CNT_W-1:0]    wait_cnt;
        logic [AVG_LOG2-1:0] smp_cnt;
    } seq_s;

    seq_s d, q;

    always_comb begin
        d        = q;
        cal_take = 1'b0;
        cal_done = 1'b0;
        run_take = 1'b0;
        if (!awake) begin
            d.state = ST_SLEEP;
        end else begin
            unique case (q.state)
                ST_SLEEP: begin
                    d.smp_cnt = '0;
                    if (user_mode) begin
                        d.state    = ST_SETTLE;
                        d.wait_cnt = CNT_W'(SETTLE_USER);
                    end else begin
                        d.state = ST_CAL;
                    end
                end
                ST_CAL: begin
                    if (smp_valid) begin
                        cal_take  = 1'b1;
                        d.smp_cnt = q.smp_cnt + 1'b1;
                        if (q.smp_cnt == LAST_SMP) begin
                            cal_done   = 1'b1;
                            d.state    = ST_SETTLE;
                            d.wait_cnt = CNT_W'(SETTLE_AUTO);
                        end
                    end
                end
                ST_SETTLE: begin
                    if (q.wait_cnt == '0) begin
                        d.state = ST_RUN;
                    end else begin
                        d.wait_cnt = q.wait_cnt - 1'b1;
                    end
                end
                ST_RUN: begin
                    run_take = smp_valid;
                end
                default: d.state = ST_SLEEP;
            endcase
        end
    end

    assign cal_active = (q.state == ST_CAL);
    assign acc_clear  = (q.state == ST_SLEEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_SLEEP;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/iq_dc_trim.sv
// Top: trim word storage, per-channel datapaths and output register.
module iq_dc_trim
    import iq_trim_pkg::*;
#(
    parameter int SAMP_W      = 15,
    parameter int OFS_W       = 10,
    parameter int AVG_LOG2    = 4,
    parameter int SETTLE_AUTO = 10221,
    parameter int SETTLE_USER = 6141
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_user_mode,
    input  logic              rx_awake,
    input  logic              ofs_wr_en,
    input  logic              ofs_wr_sel,
    input  logic [OFS_W-1:0]  ofs_wr_data,
    input  logic              smp_valid,
    input  logic [SAMP_W-1:0] smp_i,
    input  logic [SAMP_W-1:0] smp_q,
    output logic              short_req,
    output logic              out_valid,
    output logic [SAMP_W-1:0] out_i,
    output logic [SAMP_W-1:0] out_q,
    output logic [OFS_W-1:0]  ofs_i,
    output logic [OFS_W-1:0]  ofs_q
);
    // trim word spans one eighth of the sample range
    localparam int OFS_SHIFT = SAMP_W - OFS_W - 3;

    typedef struct packed {
        logic [NUM_CH-1:0][OFS_W-1:0]  ofs;
        logic                          vld;
        logic [NUM_CH-1:0][SAMP_W-1:0] res;
    } top_s;

    top_s d, q;

    logic acc_clear, cal_take, cal_done, run_take, cal_active;
    logic [NUM_CH-1:0][SAMP_W-1:0] smp_bus, corr_bus;
    logic [NUM_CH-1:0][OFS_W-1:0]  est_bus;

    assign smp_bus[0] = smp_i;
    assign smp_bus[1] = smp_q;

    iq_cal_seq #(
        .AVG_LOG2    (AVG_LOG2),
        .SETTLE_AUTO (SETTLE_AUTO),
        .SETTLE_USER (SETTLE_USER)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .user_mode  (cfg_user_mode),
        .awake      (rx_awake),
        .smp_valid  (smp_valid),
        .cal_active (cal_active),
        .acc_clear  (acc_clear),
        .cal_take   (cal_take),
        .cal_done   (cal_done),
        .run_take   (run_take)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        iq_ofs_avg #(
            .SAMP_W    (SAMP_W),
            .OFS_W     (OFS_W),
            .AVG_LOG2  (AVG_LOG2),
            .OFS_SHIFT (OFS_SHIFT)
        ) u_avg (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (acc_clear),
            .take   (cal_take),
            .sample (smp_bus[ch]),
            .est    (est_bus[ch])
        );

        iq_ofs_apply #(
            .SAMP_W    (SAMP_W),
            .OFS_W     (OFS_W),
            .OFS_SHIFT (OFS_SHIFT)
        ) u_apply (
            .sample (smp_bus[ch]),
            .ofs    (q.ofs[ch]),
            .corr   (corr_bus[ch])
        );
    end

    always_comb begin
        d     = q;
        d.vld = run_take;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (cal_done) begin
                d.ofs[ch] = est_bus[ch];
            end else if (ofs_wr_en && cfg_user_mode && (ofs_wr_sel == 1'(ch))) begin
                d.ofs[ch] = ofs_wr_data;
            end
            if (run_take) begin
                d.res[ch] = corr_bus[ch];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign short_req = cal_active;
    assign out_valid = q.vld;
    assign out_i     = q.res[0];
    assign out_q     = q.res[1];
    assign ofs_i     = q.ofs[0];
    assign ofs_q     = q.ofs[1];

endmodule

// File: rtl/iq_dc_trim_chk.sv
module iq_dc_trim_chk #(
    parameter int OFS_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_user_mode,
    input logic             rx_awake,
    input logic             ofs_wr_en,
    input logic             smp_valid,
    input logic             short_req,
    input logic             out_valid,
    input logic [OFS_W-1:0] ofs_i,
    input logic [OFS_W-1:0] ofs_q
);
    // R4
    short_req_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_req) |-> (!$past(cfg_user_mode) && $past(rx_awake)));

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_awake |=> (!out_valid && !short_req));

    // R7
    ofs_i_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_i != $past(ofs_i)) |-> ($past(ofs_wr_en && cfg_user_mode) || $past(short_req)));

    // R7
    ofs_q_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_q != $past(ofs_q)) |-> ($past(ofs_wr_en && cfg_user_mode) || $past(short_req)));

    // R2
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_valid));

    // R8
    no_out_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_req |-> !out_valid);

endmodule

bind iq_dc_trim iq_dc_trim_chk #(.OFS_W(OFS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_user_mode (cfg_user_mode),
    .rx_awake      (rx_awake),
    .ofs_wr_en     (ofs_wr_en),
    .smp_valid     (smp_valid),
    .short_req     (short_req),
    .out_valid     (out_valid),
    .ofs_i         (ofs_i),
    .ofs_q         (ofs_q)
);

// File: tb/iq_dc_trim_tb.sv
`timescale 1ns/1ps
module iq_dc_trim_tb;
    localparam int SW = 15;
    localparam int OW = 10;
    localparam int SA = 20;
    localparam int SU = 12;

    // rows: sample I, sample Q, trim I, trim Q, expected I, expected Q
    localparam int VEC [8][6] = '{
        '{100, -100, 5, -5, 80, -80},
        '{16383, -16384, -512, 511, 16383, -16384},
        '{0, 0, 0, 0, 0, 0},
        '{-16384, 16383, -1, 1, -16380, 16379},
        '{16000, -16000, -200, 200, 16383, -16384},
        '{1234, -4321, 100, -100, 834, -3921},
        '{16380, 5, -1, 2, 16383, -3},
        '{-2, 3, 511, -512, -2046, 2051}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_user_mode = 1'b0, rx_awake = 1'b0, ofs_wr_en = 1'b0, ofs_wr_sel = 1'b0;
    logic [OW-1:0] ofs_wr_data = '0;
    logic smp_valid = 1'b0;
    logic [SW-1:0] smp_i = '0, smp_q = '0;
    logic short_req, out_valid;
    logic [SW-1:0] out_i, out_q;
    logic [OW-1:0] ofs_i, ofs_q;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    iq_dc_trim #(.SETTLE_AUTO(SA), .SETTLE_USER(SU)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_user_mode(cfg_user_mode), .rx_awake(rx_awake),
        .ofs_wr_en(ofs_wr_en), .ofs_wr_sel(ofs_wr_sel), .ofs_wr_data(ofs_wr_data),
        .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q), .short_req(short_req),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .ofs_i(ofs_i), .ofs_q(ofs_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sv(input logic [SW-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int ov(input logic [OW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic go_sleep();
        @(negedge clk);
        rx_awake  = 1'b0;
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // wake with a constant pair valid every cycle; measure first output edge
    task automatic wake_measure(input logic mode, input int si, input int sq,
                                output int edges, output int shorts);
        @(negedge clk);
        cfg_user_mode = mode;
        smp_i     = SW'(si);
        smp_q     = SW'(sq);
        smp_valid = 1'b1;
        rx_awake  = 1'b1;
        edges  = 0;
        shorts = 0;
        for (int k = 0; k < 400; k++) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (short_req) shorts++;
            if (out_valid) break;
        end
        smp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int e, s;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ofs_i", ov(ofs_i), 0);
        chk("R1 ofs_q", ov(ofs_q), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 short_req", int'(short_req), 0);
        rst_n = 1'b1;

        // R6 R8 held-mode wake from reset
        wake_measure(1'b1, 0, 0, e, s);
        chk("R8 held latency", e, SU + 3);
        chk("R6 held no short", s, 0);
        chk("R6 held ofs_i", ov(ofs_i), 0);

        // R2 R3 R7 vector table in running state
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            ofs_wr_en = 1'b1; ofs_wr_sel = 1'b0; ofs_wr_data = OW'(VEC[r][2]);
            @(negedge clk);
            ofs_wr_sel = 1'b1; ofs_wr_data = OW'(VEC[r][3]);
            @(negedge clk);
            ofs_wr_en = 1'b0;
            smp_i = SW'(VEC[r][0]); smp_q = SW'(VEC[r][1]); smp_valid = 1'b1;
            @(negedge clk);
            smp_valid = 1'b0;
            chk("R7 write I", ov(ofs_i), VEC[r][2]);
            chk("R7 write Q", ov(ofs_q), VEC[r][3]);
            chk("R2 valid", int'(out_valid), 1);
            chk("R2/R3 out_i", sv(out_i), VEC[r][4]);
            chk("R2/R3 out_q", sv(out_q), VEC[r][5]);
        end

        // R9 sleep wins over a sample on the same edge
        @(negedge clk);
        smp_valid = 1'b1; rx_awake = 1'b0;
        @(negedge clk);
        chk("R9 no out on sleep edge", int'(out_valid), 0);
        smp_valid = 1'b0;
        @(negedge clk);

        // R6 held wake keeps trim words
        wake_measure(1'b1, 50, 50, e, s);
        chk("R6 keep ofs_i", ov(ofs_i), 511);
        chk("R6 keep ofs_q", ov(ofs_q), -512);
        chk("R6 no short", s, 0);
        go_sleep();

        // R4 R5 R8 automatic calibration, floor on negative value
        wake_measure(1'b0, 1000, -7, e, s);
        chk("R8 auto latency", e, SA + 19);
        chk("R4 short cycles", s, 16);
        chk("R5 cal ofs_i", ov(ofs_i), 250);
        chk("R5 cal ofs_q", ov(ofs_q), -2);
        chk("R2 auto out_i", sv(out_i), 0);
        chk("R2 auto out_q", sv(out_q), 1);

        // R7 write ignored in automatic mode
        @(negedge clk);
        ofs_wr_en = 1'b1; ofs_wr_sel = 1'b0; ofs_wr_data = OW'(341);
        @(negedge clk);
        ofs_wr_en = 1'b0;
        @(negedge clk);
        chk("R7 auto write ignored", ov(ofs_i), 250);
        go_sleep();

        // R5 clamping of calibration result
        wake_measure(1'b0, 16383, -16384, e, s);
        chk("R5 clamp hi", ov(ofs_i), 511);
        chk("R5 clamp lo", ov(ofs_q), -512);
        chk("R3 auto out_i", sv(out_i), 14339);
        chk("R3 auto out_q", sv(out_q), -14336);
        go_sleep();

        // R4 R5 calibration with gaps in sample validity
        @(negedge clk);
        cfg_user_mode = 1'b0; smp_valid = 1'b0; rx_awake = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            chk("R4 short held", int'(short_req), 1);
            smp_i = SW'(k * 64); smp_q = SW'(-k * 100 - 3); smp_valid = 1'b1;
            @(negedge clk);
            smp_valid = 1'b0;
            @(negedge clk);
        end
        chk("R4 short released", int'(short_req), 0);
        chk("R5 gap ofs_i", ov(ofs_i), 120);
        chk("R5 gap ofs_q", ov(ofs_q), -189);
        go_sleep();

        // R9 aborted calibration keeps trim words
        @(negedge clk);
        cfg_user_mode = 1'b0; smp_i = SW'(3000); smp_q = SW'(3000);
        smp_valid = 1'b1; rx_awake = 1'b1;
        repeat (6) @(negedge clk);
        chk("R4 short during cal", int'(short_req), 1);
        rx_awake = 1'b0; smp_valid = 1'b0;
        @(negedge clk);
        chk("R9 short dropped", int'(short_req), 0);
        chk("R9 no out", int'(out_valid), 0);
        @(negedge clk);
        chk("R9 abort ofs_i", ov(ofs_i), 120);
        chk("R9 abort ofs_q", ov(ofs_q), -189);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule